// File: doc/BRIEF.md
# Eight-Way Addressable Latch Demultiplexer

This block holds eight single-bit values that are written one at a time through a 3-bit select bus and one data input. An active-low clear and an active-low enable together choose one of four modes. In the write mode, one addressed bit is updated and the other seven are kept. In the hold mode, every bit is frozen and the select and data inputs have no effect. In the steering mode, the data input appears on the addressed output and every other output reads low. In the blanking mode, all eight outputs read low.

The block is synchronous. A system clock samples the select and data inputs, and writes happen on its rising edge. The clear acts asynchronously on the outputs and, in the default variant, on the stored bits too. A wider addressable register is built by placing several instances on a shared select and data bus and driving the enable of only one of them low at a time. Every other instance then stays in hold mode.

Top module: `addr_bit_latch`

## Requirements
- R1: While the system reset `rstN` is low, all stored bits are cleared, and after release all of `q` reads 0 while the block is in hold mode.
- R2: With `clrN`=1 and `enN`=0, the rising clock edge loads `din` into the addressed bit, the other seven bits keep their values, and `q` shows the stored bits after that edge.
- R3: With `clrN`=1 and `enN`=1, every stored bit and every bit of `q` stays unchanged for any value or change of `sel` and `din`.
- R4: With `clrN`=0 and `enN`=0, `q[sel]` equals `din` and every other bit of `q` is 0, combinationally from the current inputs.
- R5: With `clrN`=0 and `enN`=1, all bits of `q` are 0 whatever `sel` and `din` are.
- R6: With the default `DEMUX_CLEARS`=1, a low `clrN` clears the stored bits at once without waiting for a clock edge, so hold mode reads 0 afterwards.
- R7: `sel` is plain binary, so value n (0..7) addresses bit n of `q`, with `sel[2]` weighted 4.
- R8: With `DEMUX_CLEARS`=0, steering mode leaves the stored bits unchanged, and only blanking mode clears them, at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; writes happen on its rising edge |
| rstN | input | 1 | Asynchronous system reset, active low |
| clrN | input | 1 | Clear, active low; together with `enN` it selects the mode |
| enN | input | 1 | Enable, active low; together with `clrN` it selects the mode |
| sel | input | 3 | Binary address of the target bit |
| din | input | 1 | Data bit to store or to steer |
| q | output | 8 | Parallel outputs |

## Verification
The assertions take for granted that `sel`, `din`, `enN` and `clrN` are synchronous to `clk` and settle away from its rising edge. They also take for granted that no value is X once reset is released, because the mode decode and the address decode sample those inputs directly. The bench meets this by changing every input only on the falling edge, and by holding `clrN` and `enN` high while the system reset is active. Address changes under a high enable are made deliberately, to show that those sweeps leave the stored bits untouched.

// File: rtl/addr_bit_latch_pkg.sv
package addr_bit_latch_pkg;
  typedef struct packed {
    logic writeStb;
    logic holdAll;
    logic demuxOn;
    logic forceLow;
  } abl_strobe_t;
endpackage

// File: rtl/abl_ctrl.sv
module abl_ctrl
  import addr_bit_latch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clrN,
  input  logic        enN,
  output abl_strobe_t stb
);
  always_comb begin
    stb.writeStb = clrN & ~enN;
    stb.holdAll  = clrN & enN;
    stb.demuxOn  = ~clrN & ~enN;
    stb.forceLow = ~clrN & enN;
  end

  // Exactly one mode is active in any cycle (R2, R3, R4, R5).
  assert_one_mode_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({stb.writeStb, stb.holdAll, stb.demuxOn, stb.forceLow}));
endmodule

// File: rtl/abl_store.sv
module abl_store
  import addr_bit_latch_pkg::*;
#(
  parameter int ADDR_W       = 3,
  parameter bit DEMUX_CLEARS = 1'b1,
  localparam int NB          = 1 << ADDR_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clrN,
  input  abl_strobe_t       stb,
  input  logic [ADDR_W-1:0] sel,
  input  logic              din,
  output logic [NB-1:0]     q
);
  logic [NB-1:0] selHot;
  logic [NB-1:0] store;
  logic [NB-1:0] nextStore;

  for (genvar b = 0; b < NB; b++) begin : g_dec
    assign selHot[b] = (sel == ADDR_W'(b));
  end

  always_comb begin
    nextStore = store;
    if (stb.writeStb) nextStore = (store & ~selHot) | (selHot & {NB{din}});
    if (!DEMUX_CLEARS && stb.forceLow) nextStore = '0;
  end

  if (DEMUX_CLEARS) begin : g_async
    logic storeRstN;
    assign storeRstN = rstN & clrN;
    always_ff @(posedge clk or negedge storeRstN)
      if (!storeRstN) store <= '0;
      else            store <= nextStore;

    assert_clear_store_R6: assert property (@(posedge clk) disable iff (!rstN)
      !clrN |-> (store == '0));
  end else begin : g_sync
    always_ff @(posedge clk or negedge rstN)
      if (!rstN) store <= '0;
      else       store <= nextStore;

    assert_demux_keeps_R8: assert property (@(posedge clk) disable iff (!rstN)
      stb.demuxOn |=> $stable(store));
  end

  always_comb begin
    if (stb.forceLow)     q = '0;
    else if (stb.demuxOn) q = selHot & {NB{din}};
    else                  q = store;
  end

  assert_others_kept_R2: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    stb.writeStb |=> ((store & ~$past(selHot)) == ($past(store) & ~$past(selHot))));

  assert_addr_written_R7: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    stb.writeStb |=> ((|(store & $past(selHot))) == $past(din)));

  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    stb.holdAll |=> $stable(store));

  assert_demux_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.demuxOn |-> ($onehot0(q) && ((q & ~selHot) == '0)));

  assert_blank_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.forceLow |-> (q == '0));
endmodule

// File: rtl/addr_bit_latch.sv
module addr_bit_latch
  import addr_bit_latch_pkg::*;
#(
  parameter int ADDR_W       = 3,
  parameter bit DEMUX_CLEARS = 1'b1,
  localparam int NB          = 1 << ADDR_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clrN,
  input  logic              enN,
  input  logic [ADDR_W-1:0] sel,
  input  logic              din,
  output logic [NB-1:0]     q
);
  abl_strobe_t stb;

  abl_ctrl ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .clrN (clrN),
    .enN  (enN),
    .stb  (stb)
  );

  abl_store #(.ADDR_W(ADDR_W), .DEMUX_CLEARS(DEMUX_CLEARS)) store_i (
    .clk  (clk),
    .rstN (rstN),
    .clrN (clrN),
    .stb  (stb),
    .sel  (sel),
    .din  (din),
    .q    (q)
  );
endmodule

// File: tb/addr_bit_latch_tb.sv
module addr_bit_latch_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clrN = 1'b1;
  logic enN = 1'b1;
  logic [2:0] sel = '0;
  logic din = 1'b0;
  logic [7:0] qA, qB;
  logic [7:0] refA = '0, refB = '0;
  int nChecks = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  addr_bit_latch dut_i (
    .clk(clk), .rstN(rstN), .clrN(clrN), .enN(enN), .sel(sel), .din(din), .q(qA));

  addr_bit_latch #(.DEMUX_CLEARS(1'b0)) dut_keep_i (
    .clk(clk), .rstN(rstN), .clrN(clrN), .enN(enN), .sel(sel), .din(din), .q(qB));

  function automatic logic [7:0] expectQ(input logic c, input logic e,
                                         input logic [2:0] s, input logic d,
                                         input logic [7:0] r);
    if (!c && e)  return 8'h00;
    if (!c && !e) return d ? (8'd1 << s) : 8'h00;
    return r;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: q=%02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic c, input logic e, input logic [2:0] s,
                      input logic d, input string tag);
    @(negedge clk);
    clrN = c; enN = e; sel = s; din = d;
    @(posedge clk);
    if (c && !e) begin refA[s] = d; refB[s] = d; end
    if (!c) refA = '0;
    if (!c && e) refB = '0;
    #1;
    check({tag, " A"}, qA, expectQ(c, e, s, d, refA));
    check({tag, " B"}, qB, expectQ(c, e, s, d, refB));
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1 reset A", qA, 8'h00);
    check("R1 reset B", qB, 8'h00);

    // R2 / R7: write ones to each address in turn, then an alternating pattern
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 3'(i), 1'b1, "R7 walk ones");
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 3'(i), i[0], "R2 alternate");
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 3'((i * 5 + 3) % 8), i[1], "R2 scrambled");

    // R3: address and data change under a high enable; nothing may move
    for (int i = 0; i < 16; i++) step(1'b1, 1'b1, 3'((i * 3 + 1) % 8), ~i[0], "R3 hold sweep");

    // Enable toggles while the address changes
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 1'b1, 3'(7 - i), 1'b1, "R3 idle address");
      step(1'b1, 1'b0, 3'(i), ~refA[i], "R2 toggled write");
    end

    // R4: steering mode, every address and both data levels
    for (int i = 0; i < 16; i++) step(1'b0, 1'b0, 3'(i), i[3], "R4 demux");

    // R8 / R6: back to hold, kept variant still holds its pattern
    step(1'b1, 1'b1, 3'd5, 1'b1, "R8 after demux");

    // R6: clear takes effect before any clock edge
    @(negedge clk);
    clrN = 1'b0; enN = 1'b1;
    #1;
    check("R6 async clear A", qA, 8'h00);
    check("R5 blank B", qB, 8'h00);

    // R5: blanking mode, every address
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 3'(i), 1'b1, "R5 blank");
    step(1'b1, 1'b1, 3'd2, 1'b1, "R6 hold after clear");

    // Refill and check once more
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 3'(i), i[2], "R7 refill");

    finishRun();
  end
endmodule